// File: doc/BRIEF.md
# Pin-Change Interrupt Unit

This block watches the eight pins of one I/O port and raises a single interrupt request when a chosen edge appears on any pin that software has armed. Each pin is sampled through a two-stage synchronizer. It then passes through a glitch filter: a new level is accepted only after it has stayed unchanged for a set number of clocks. An edge detector runs on the filtered level. Shorter pulses leave no trace.

The unit samples the pad level directly, so it reports changes even while the pin is being driven as an output by other logic. Each pin has its own enable bit and its own polarity bit. The detected edges set sticky flags, which software clears by writing ones. The enabled flags are ORed into one request line and into a matching wake request.

A small synchronous register port gives access to four locations: enables, polarities, flags, and a read-only view of the filtered levels.

Top module: `pcint_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, the enable, polarity and flag registers and the filtered levels all read 0, and `irq_o` and `wake_o` are low. Reset is asynchronous and active low.
- R2: A level change on a pin appears in the filtered-level view (address 3) exactly 2+FILT_CYCLES rising clock edges after the change. There are two synchronizer stages followed by FILT_CYCLES stable samples. It does not appear one edge earlier.
- R3: A pulse that is stable for fewer than FILT_CYCLES synchronized clocks neither changes the filtered level nor sets a flag. A pulse lasting exactly FILT_CYCLES clocks is accepted.
- R4: Polarity bit value 1 selects the rising edge of the filtered level and value 0 selects the falling edge. The pin's flag bit is set one clock after the filtered level changes in the selected direction, whether or not the pin is enabled. Edges in the other direction leave the flag unchanged.
- R5: A write to address 2 clears every flag bit whose write-data bit is 1. Flag bits written with 0 keep their value.
- R6: If a qualifying edge sets a flag bit in the same clock as a write that clears that bit, the bit stays set.
- R7: `irq_o` is high exactly when at least one pin has both its flag bit and its enable bit set. It follows register changes with no extra delay, including enabling a pin whose flag is already set.
- R8: `wake_o` always equals `irq_o`.
- R9: Address 0 holds the enables and address 1 holds the polarities; both are read/write. Address 3 is read only, and writes to it change nothing. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | PINS | Pad levels of the port |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data for `bus_addr` |
| irq_o | output | 1 | Shared interrupt request |
| wake_o | output | 1 | Wake request to the low-power controller |

## Verification
The hardest case to reach is a clearing write that lands in the very clock in which a new qualifying edge sets the same flag. The filter latency hides the edge from the ports until its effect shows up. The stimulus first sets the flag and returns the pin to its idle level. It then raises the pin again at a known falling clock edge and counts 2+FILT_CYCLES rising edges. The clear is asserted for exactly the following edge, so both events land together. A control write one clock later must clear the flag. The latency check and the one-short and exact-length pulse checks use the same counted-edge method to hit the filter boundary exactly.

// File: rtl/pcint_pkg.sv
package pcint_pkg;

    localparam int REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        SEL_ENABLE = 2'd0,
        SEL_POLAR  = 2'd1,
        SEL_FLAGS  = 2'd2,
        SEL_LEVEL  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] safe;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = d_i;
        st_d.safe = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.safe;

endmodule

// File: rtl/pcint_filter.sv
module pcint_filter #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o
);

    localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw_i == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.lvl = raw_i;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;

endmodule

// File: rtl/pcint_edge.sv
module pcint_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    typedef struct packed {
        logic [W-1:0] prev;
    } edg_t;

    edg_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = lvl_i & ~st_q.prev;
    assign fall_o = ~lvl_i & st_q.prev;

endmodule

// File: rtl/pcint_ctrl.sv
module pcint_ctrl
    import pcint_pkg::*;
#(
    parameter int PINS        = 8,
    parameter int FILT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pin_i,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    output logic              irq_o,
    output logic              wake_o
);

    typedef struct packed {
        logic [PINS-1:0] en;
        logic [PINS-1:0] pol;
        logic [PINS-1:0] flag;
    } regs_t;

    regs_t rg_d, rg_q;

    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] pin_lvl;
    logic [PINS-1:0] lvl_rise;
    logic [PINS-1:0] lvl_fall;
    logic [PINS-1:0] edge_hit;
    logic [PINS-1:0] en_r;
    logic [PINS-1:0] flag_r;

    pcint_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_sync)
    );

    for (genvar g = 0; g < PINS; g++) begin : g_flt
        pcint_filter #(.CYC(FILT_CYCLES)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (pin_sync[g]),
            .lvl_o (pin_lvl[g])
        );
    end

    pcint_edge #(.W(PINS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pin_lvl),
        .rise_o (lvl_rise),
        .fall_o (lvl_fall)
    );

    assign edge_hit = (lvl_rise & rg_q.pol) | (lvl_fall & ~rg_q.pol);

    always_comb begin
        rg_d = rg_q;
        if (bus_we) begin
            unique case (reg_sel_e'(bus_addr))
                SEL_ENABLE: rg_d.en   = bus_wdata;
                SEL_POLAR:  rg_d.pol  = bus_wdata;
                SEL_FLAGS:  rg_d.flag = rg_q.flag & ~bus_wdata;
                default:    rg_d      = rg_q;
            endcase
        end
        // a new edge is merged after the clear so it survives a same-cycle write
        rg_d.flag = rg_d.flag | edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign en_r   = rg_q.en;
    assign flag_r = rg_q.flag;

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            SEL_ENABLE: bus_rdata = en_r;
            SEL_POLAR:  bus_rdata = rg_q.pol;
            SEL_FLAGS:  bus_rdata = flag_r;
            default:    bus_rdata = pin_lvl;
        endcase
    end

    assign irq_o  = |(flag_r & en_r);
    assign wake_o = |(rg_q.flag & rg_q.en);

endmodule

// File: rtl/pcint_ctrl_chk.sv
module pcint_ctrl_chk
    import pcint_pkg::*;
#(
    parameter int PINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] bus_addr,
    input logic              bus_we,
    input logic [PINS-1:0]   bus_wdata,
    input logic              irq_o,
    input logic              wake_o,
    input logic [PINS-1:0]   en,
    input logic [PINS-1:0]   flags,
    input logic [PINS-1:0]   lvl,
    input logic [PINS-1:0]   sync,
    input logic [PINS-1:0]   hit
);

    // R2
    level_from_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl ^ $past(lvl)) & (lvl ^ $past(sync))) == '0);

    // R4
    flag_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~$past(flags)) != '0) |-> ($past(lvl) != $past(lvl, 2)));

    // R5
    clear_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_addr == SEL_FLAGS) |->
            ((flags & $past(bus_wdata) & ~$past(hit)) == '0));

    // R6
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & $past(hit)) == $past(hit)));

    // R7
    no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq_o);

    // R8
    wake_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o == irq_o);

    // R9
    enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_addr == SEL_ENABLE) |-> (en == $past(bus_wdata)));

endmodule

bind pcint_ctrl pcint_ctrl_chk #(.PINS(PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .wake_o    (wake_o),
    .en        (en_r),
    .flags     (flag_r),
    .lvl       (pin_lvl),
    .sync      (pin_sync),
    .hit       (edge_hit)
);

// File: tb/pcint_ctrl_test.sv
module pcint_ctrl_test;

    localparam int F = 4;
    localparam logic [1:0] A_EN = 2'd0, A_POL = 2'd1, A_FLG = 2'd2, A_LVL = 2'd3;

    // {start, final, polarity, enable, expected flags, expected irq}
    localparam logic [40:0] VEC [5] = '{
        {8'h00, 8'hFF, 8'hFF, 8'h01, 8'hFF, 1'b1},
        {8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00, 1'b0},
        {8'hFF, 8'h00, 8'h00, 8'h80, 8'hFF, 1'b1},
        {8'h0F, 8'hF0, 8'hA5, 8'h00, 8'hAA, 1'b0},
        {8'h33, 8'h55, 8'h0F, 8'h0F, 8'h24, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = '0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_o, wake_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pcint_ctrl #(.PINS(8), .FILT_CYCLES(F)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .wake_o    (wake_o)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic settle();
        repeat (F + 6) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, s, f, p, e, ef;
        logic       ei;

        repeat (3) @(posedge clk);
        // R1: state held in reset
        #1 bus_addr = A_FLG;
        #1 chk("R1 flags in reset", bus_rdata, 8'h00);
        chk("R1 irq in reset", {7'd0, irq_o}, 8'h00);
        @(negedge clk) rst_n = 1'b1;
        rd(A_EN, v);  chk("R1 enable", v, 8'h00);
        rd(A_POL, v); chk("R1 polarity", v, 8'h00);
        rd(A_FLG, v); chk("R1 flags", v, 8'h00);
        rd(A_LVL, v); chk("R1 levels", v, 8'h00);
        chk("R1 wake", {7'd0, wake_o}, 8'h00);

        // table of edge patterns: R4 R7 R8
        for (int i = 0; i < 5; i++) begin
            {s, f, p, e, ef, ei} = VEC[i];
            wr(A_EN, 8'h00);
            wr(A_POL, p);
            @(negedge clk) pin_i = s;
            settle();
            wr(A_FLG, 8'hFF);
            wr(A_EN, e);
            @(negedge clk) pin_i = f;
            settle();
            rd(A_FLG, v); chk("R4 flags per polarity", v, ef);
            chk("R7 irq", {7'd0, irq_o}, {7'd0, ei});
            chk("R8 wake", {7'd0, wake_o}, {7'd0, ei});
        end

        // R9: readback and read-only level view
        rd(A_POL, v); chk("R9 polarity readback", v, 8'h0F);
        rd(A_EN, v);  chk("R9 enable readback", v, 8'h0F);
        wr(A_LVL, 8'h00);
        rd(A_LVL, v); chk("R9 level write ignored", v, 8'h55);

        // back to quiet state, all rising
        wr(A_EN, 8'h00);
        wr(A_POL, 8'hFF);
        @(negedge clk) pin_i = 8'h00;
        settle();
        wr(A_FLG, 8'hFF);

        // R2: exact latency on pin 0
        @(negedge clk) pin_i[0] = 1'b1;
        bus_addr = A_LVL;
        repeat (F + 1) @(posedge clk);
        @(negedge clk); #1 chk("R2 level one edge early", bus_rdata, 8'h00);
        @(posedge clk);
        @(negedge clk); #1 chk("R2 level on time", bus_rdata, 8'h01);
        bus_addr = A_FLG;
        #1 chk("R4 flag not yet set", bus_rdata, 8'h00);
        @(posedge clk);
        @(negedge clk); #1 chk("R4 flag one clock later", bus_rdata, 8'h01);

        // R7: enabling an already-set flag raises irq at once
        chk("R7 irq while disabled", {7'd0, irq_o}, 8'h00);
        @(negedge clk) bus_addr = A_EN; bus_wdata = 8'h01; bus_we = 1'b1;
        @(posedge clk); #1 chk("R7 irq after enable", {7'd0, irq_o}, 8'h01);
        @(negedge clk) bus_we = 1'b0;

        // R3: short pulse rejected, exact-length pulse accepted (pin 1)
        @(negedge clk) pin_i[1] = 1'b1;
        repeat (F - 1) @(negedge clk);
        pin_i[1] = 1'b0;
        settle();
        rd(A_FLG, v); chk("R3 short pulse no flag", v & 8'h02, 8'h00);
        rd(A_LVL, v); chk("R3 short pulse no level", v & 8'h02, 8'h00);
        @(negedge clk) pin_i[1] = 1'b1;
        repeat (F) @(negedge clk);
        pin_i[1] = 1'b0;
        settle();
        rd(A_FLG, v); chk("R3 full pulse sets flag", v & 8'h02, 8'h02);

        // R6: clear and new edge on pin 2 in the same clock
        @(negedge clk) pin_i[2] = 1'b1;
        settle();
        @(negedge clk) pin_i[2] = 1'b0;
        settle();
        rd(A_FLG, v); chk("R4 falling ignored, flag kept", v & 8'h04, 8'h04);
        @(negedge clk) pin_i[2] = 1'b1;
        repeat (F + 2) @(posedge clk);
        @(negedge clk) bus_addr = A_FLG; bus_wdata = 8'h04; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk) bus_we = 1'b0;
        rd(A_FLG, v); chk("R6 edge beats clear", v & 8'h04, 8'h04);

        // R5: write-one clears, write-zero keeps
        wr(A_FLG, 8'h04);
        rd(A_FLG, v); chk("R5 one clears", v & 8'h04, 8'h00);
        wr(A_FLG, 8'h00);
        rd(A_FLG, v); chk("R5 zero keeps", v & 8'h03, 8'h03);
        wr(A_FLG, 8'h01);
        chk("R7 irq drops after clear", {7'd0, irq_o}, 8'h00);
        chk("R8 wake drops after clear", {7'd0, wake_o}, 8'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule